// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block lays a 64 by 64 pixel hardware cursor over the pixel stream on its way to the display. Each cursor pixel has two bits, A and B. In video memory a bitmap row is stored as pairs of 16-bit words: first the A bits of 16 neighbouring columns, then the B bits of the same columns. The A/B pair picks one of four results: the screen pixel unchanged, the screen pixel inverted, the foreground colour or the background colour. A control bit selects which of two mappings is used.

Software configures the cursor through a byte-wide indexed register port. The port holds the enable bit, the encoding select, the cursor origin, the bitmap base address and the pattern offsets, plus two four-deep colour stacks with a write pointer. At the rising edge of horizontal blanking the block works out whether the next scanline crosses the cursor. If it does, the block reads that bitmap row from memory into a 128-bit line buffer. During the active part of the line, the beam X counter selects a column from that buffer.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, all four foreground stack slots hold 0xFF, all four background slots hold 0x00, and the cursor is disabled, so pix_out follows pix_in.
- R2: A write to index 10 (foreground) or index 11 (background) stores into the slot at that stack's pointer, then advances the pointer modulo 4. A read of the same index returns the slot at the pointer and sets the pointer to 0.
- R3: The X origin is written at indices 2 (bits 10:8, taken from data bits 2:0) and 3 (bits 7:0). The Y origin is written at indices 4 (high) and 5 (low). These writes are held staged, and the staged values read back. Both coordinates take effect together only when index 4 is written.
- R4: Bit 0 of the mode register (index 0) enables the cursor. While the cursor is disabled, and for any pixel outside the cursor, pix_out equals pix_in.
- R5: At the rising edge of hblank, if line beam_y+1 lies in the cursor window, the block reads eight 16-bit words. Word w (w = 0 to 7) is read at byte address base*1024 + row*16 + 2*w. Even-numbered words hold A bits and odd-numbered words hold B bits, for columns 16*(w/2) upward, with bit 15 being the leftmost pixel. Each request holds its address until mem_ack.
- R6: With bit 4 of the encoding register (index 1) clear, AB=00 gives the background colour, 01 the foreground colour, 10 the screen pixel and 11 the inverted screen pixel.
- R7: With bit 4 of index 1 set, AB=00 and AB=01 give the screen pixel, 10 the background colour and 11 the foreground colour.
- R8: The bitmap column is beam_x - X + off_x and the bitmap row is line - Y + off_y. The 6-bit offsets are at indices 8 and 9. A pixel is part of the cursor only when the difference is not negative and the column or row is below 64.
- R9: For a line outside the cursor window, the block issues no memory request and outputs the screen pixel.
- R10: The colours used for the cursor are slot 0 of each stack. The base address is set at index 6 (high bits) and index 7 (low byte).
- R11: pix_out is registered, so it reflects the beam_x and pix_in values of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the strobe cycle |
| mem_req | output | 1 | Bitmap word request |
| mem_addr | output | 22 | Byte address of requested word |
| mem_ack | input | 1 | Request accepted, data valid |
| mem_rdata | input | 16 | Bitmap word |
| beam_x | input | 11 | Current pixel column |
| beam_y | input | 11 | Current scanline |
| hblank | input | 1 | Horizontal blanking |
| pix_in | input | 8 | Screen pixel |
| pix_out | output | 8 | Pixel with cursor overlaid |

## Verification
The bench builds the block with its default parameters: an 11-bit beam, a 22-bit memory address, 8-bit pixels and a 64-pixel cursor. The 11-bit beam lets the bench place the Y origin above 255, so the high byte of the origin actually matters and the commit-on-Y-high rule can be seen. The 22-bit address lets the bench use a nonzero base address whose high bits are not masked. The full 64-column width lets the bench reach the word-pair boundary at column 16 and both the last and first-outside columns and rows.

// File: rtl/cur_pkg.sv
package cur_pkg;
    typedef enum logic [3:0] {
        IDX_MODE  = 4'd0,
        IDX_ENC   = 4'd1,
        IDX_XHI   = 4'd2,
        IDX_XLO   = 4'd3,
        IDX_YHI   = 4'd4,
        IDX_YLO   = 4'd5,
        IDX_BHI   = 4'd6,
        IDX_BLO   = 4'd7,
        IDX_OFFX  = 4'd8,
        IDX_OFFY  = 4'd9,
        IDX_FG    = 4'd10,
        IDX_BG    = 4'd11
    } reg_idx_e;

    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,
        FS_RUN  = 1'b1
    } fetch_st_e;
endpackage

// File: rtl/cur_regs.sv
module cur_regs #(
    parameter int PIX_W   = 8,
    parameter int COORD_W = 11,
    parameter int BASE_W  = 12,
    parameter int OFF_W   = 6,
    parameter int STK     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               re,
    input  logic [3:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic               cur_en,
    output logic               enc_sel,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic [BASE_W-1:0]  base,
    output logic [OFF_W-1:0]   off_x,
    output logic [OFF_W-1:0]   off_y,
    output logic [PIX_W-1:0]   fg0,
    output logic [PIX_W-1:0]   bg0,
    output logic [$clog2(STK)-1:0] fg_ptr
);
    import cur_pkg::*;
    localparam int PTR_W = $clog2(STK);

    typedef struct packed {
        logic [7:0]                  mode;
        logic [7:0]                  enc;
        logic [COORD_W-1:0]          xs;
        logic [COORD_W-1:0]          ys;
        logic [COORD_W-1:0]          px;
        logic [COORD_W-1:0]          py;
        logic [BASE_W-1:0]           base;
        logic [OFF_W-1:0]            ox;
        logic [OFF_W-1:0]            oy;
        logic [STK-1:0][PIX_W-1:0]   fg;
        logic [STK-1:0][PIX_W-1:0]   bg;
        logic [PTR_W-1:0]            fp;
        logic [PTR_W-1:0]            bp;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d   = r_q;
        rdata = 8'h00;
        if (re) begin
            case (addr)
                IDX_MODE: rdata = r_q.mode;
                IDX_ENC:  rdata = r_q.enc;
                IDX_XHI:  rdata = 8'(r_q.xs >> 8);
                IDX_XLO:  rdata = r_q.xs[7:0];
                IDX_YHI:  rdata = 8'(r_q.ys >> 8);
                IDX_YLO:  rdata = r_q.ys[7:0];
                IDX_BHI:  rdata = 8'(r_q.base >> 8);
                IDX_BLO:  rdata = r_q.base[7:0];
                IDX_OFFX: rdata = 8'(r_q.ox);
                IDX_OFFY: rdata = 8'(r_q.oy);
                IDX_FG: begin
                    rdata  = 8'(r_q.fg[r_q.fp]);
                    r_d.fp = '0;
                end
                IDX_BG: begin
                    rdata  = 8'(r_q.bg[r_q.bp]);
                    r_d.bp = '0;
                end
                default: rdata = 8'h00;
            endcase
        end
        if (we) begin
            case (addr)
                IDX_MODE: r_d.mode = wdata;
                IDX_ENC:  r_d.enc  = wdata;
                IDX_XHI:  r_d.xs   = COORD_W'({wdata, r_q.xs[7:0]});
                IDX_XLO:  r_d.xs   = COORD_W'({r_q.xs >> 8, wdata});
                IDX_YHI: begin
                    r_d.ys = COORD_W'({wdata, r_q.ys[7:0]});
                    r_d.py = COORD_W'({wdata, r_q.ys[7:0]});
                    r_d.px = r_q.xs;
                end
                IDX_YLO:  r_d.ys   = COORD_W'({r_q.ys >> 8, wdata});
                IDX_BHI:  r_d.base = BASE_W'({wdata, r_q.base[7:0]});
                IDX_BLO:  r_d.base = BASE_W'({r_q.base >> 8, wdata});
                IDX_OFFX: r_d.ox   = wdata[OFF_W-1:0];
                IDX_OFFY: r_d.oy   = wdata[OFF_W-1:0];
                IDX_FG: begin
                    r_d.fg[r_q.fp] = PIX_W'(wdata);
                    r_d.fp         = r_q.fp + 1'b1;
                end
                IDX_BG: begin
                    r_d.bg[r_q.bp] = PIX_W'(wdata);
                    r_d.bp         = r_q.bp + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.fg <= '1;
            r_q.bg <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_en  = r_q.mode[0];
    assign enc_sel = r_q.enc[4];
    assign pos_x   = r_q.px;
    assign pos_y   = r_q.py;
    assign base    = r_q.base;
    assign off_x   = r_q.ox;
    assign off_y   = r_q.oy;
    assign fg0     = r_q.fg[0];
    assign bg0     = r_q.bg[0];
    assign fg_ptr  = r_q.fp;
endmodule

// File: rtl/cur_fetch.sv
module cur_fetch #(
    parameter int COORD_W = 11,
    parameter int ADDR_W  = 22,
    parameter int DIM     = 64,
    parameter int MEM_W   = 16,
    localparam int OFF_W  = $clog2(DIM),
    localparam int WORDS  = (DIM * 2) / MEM_W,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int MB_SH  = $clog2(MEM_W / 8),
    localparam int BASE_W = ADDR_W - OFF_W - WIDX_W - MB_SH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hblank,
    input  logic [COORD_W-1:0]          beam_y,
    input  logic [COORD_W-1:0]          pos_y,
    input  logic [OFF_W-1:0]            off_y,
    input  logic [BASE_W-1:0]           base,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic                        mem_ack,
    input  logic [MEM_W-1:0]            mem_rdata,
    output logic [WORDS-1:0][MEM_W-1:0] line_buf,
    output logic                        line_ok
);
    import cur_pkg::*;

    typedef struct packed {
        fetch_st_e                  st;
        logic                       hb;
        logic [OFF_W-1:0]           row;
        logic [WIDX_W-1:0]          widx;
        logic [WORDS-1:0][MEM_W-1:0] buf_w;
        logic                       ok;
    } fetch_t;

    fetch_t f_q, f_d;

    logic [COORD_W:0]   nxt_line;
    logic [COORD_W:0]   dy;
    logic [COORD_W+1:0] row_sum;
    logic               above;
    logic               vis;

    always_comb begin
        nxt_line = {1'b0, beam_y} + 1'b1;
        above    = nxt_line < {1'b0, pos_y};
        dy       = nxt_line - {1'b0, pos_y};
        row_sum  = {1'b0, dy} + (COORD_W+2)'(off_y);
        vis      = !above && (row_sum < (COORD_W+2)'(DIM));

        f_d    = f_q;
        f_d.hb = hblank;
        case (f_q.st)
            FS_IDLE: begin
                if (hblank && !f_q.hb) begin
                    f_d.ok = 1'b0;
                    if (vis) begin
                        f_d.st   = FS_RUN;
                        f_d.row  = row_sum[OFF_W-1:0];
                        f_d.widx = '0;
                    end
                end
            end
            FS_RUN: begin
                if (mem_ack) begin
                    f_d.buf_w[f_q.widx] = mem_rdata;
                    if (f_q.widx == WIDX_W'(WORDS - 1)) begin
                        f_d.st = FS_IDLE;
                        f_d.ok = 1'b1;
                    end else begin
                        f_d.widx = f_q.widx + 1'b1;
                    end
                end
            end
            default: f_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign mem_req  = (f_q.st == FS_RUN);
    assign mem_addr = {base, f_q.row, f_q.widx, {MB_SH{1'b0}}};
    assign line_buf = f_q.buf_w;
    assign line_ok  = f_q.ok;
endmodule

// File: rtl/cur_mix.sv
module cur_mix #(
    parameter int PIX_W   = 8,
    parameter int COORD_W = 11,
    parameter int DIM     = 64,
    parameter int MEM_W   = 16,
    localparam int OFF_W  = $clog2(DIM),
    localparam int WORDS  = (DIM * 2) / MEM_W,
    localparam int BIT_W  = $clog2(MEM_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [COORD_W-1:0]          beam_x,
    input  logic [PIX_W-1:0]            pix_in,
    input  logic [COORD_W-1:0]          pos_x,
    input  logic [OFF_W-1:0]            off_x,
    input  logic                        cur_en,
    input  logic                        enc_sel,
    input  logic [PIX_W-1:0]            fg,
    input  logic [PIX_W-1:0]            bg,
    input  logic [WORDS-1:0][MEM_W-1:0] line_buf,
    input  logic                        line_ok,
    output logic [PIX_W-1:0]            pix_out
);
    typedef struct packed {
        logic [PIX_W-1:0] pix;
    } mix_t;

    mix_t m_q, m_d;

    logic [COORD_W:0]         dx;
    logic [COORD_W+1:0]       col;
    logic                     in_win;
    logic [OFF_W-1:0]         cidx;
    logic [OFF_W-BIT_W-1:0]   pair;
    logic [MEM_W-1:0]         wa, wb;
    logic                     bit_a, bit_b;

    always_comb begin
        dx     = {1'b0, beam_x} - {1'b0, pos_x};
        col    = {1'b0, dx} + (COORD_W+2)'(off_x);
        in_win = !dx[COORD_W] && (col < (COORD_W+2)'(DIM));
        cidx   = col[OFF_W-1:0];
        pair   = cidx[OFF_W-1:BIT_W];
        wa     = line_buf[{pair, 1'b0}];
        wb     = line_buf[{pair, 1'b1}];
        bit_a  = wa[~cidx[BIT_W-1:0]];
        bit_b  = wb[~cidx[BIT_W-1:0]];

        m_d.pix = pix_in;
        if (cur_en && line_ok && in_win) begin
            if (!enc_sel) begin
                case ({bit_a, bit_b})
                    2'b00:   m_d.pix = bg;
                    2'b01:   m_d.pix = fg;
                    2'b10:   m_d.pix = pix_in;
                    default: m_d.pix = ~pix_in;
                endcase
            end else begin
                case ({bit_a, bit_b})
                    2'b10:   m_d.pix = bg;
                    2'b11:   m_d.pix = fg;
                    default: m_d.pix = pix_in;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign pix_out = m_q.pix;
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
    parameter int PIX_W   = 8,
    parameter int COORD_W = 11,
    parameter int ADDR_W  = 22,
    parameter int DIM     = 64,
    parameter int MEM_W   = 16,
    parameter int STK     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic [3:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [MEM_W-1:0]   mem_rdata,
    input  logic [COORD_W-1:0] beam_x,
    input  logic [COORD_W-1:0] beam_y,
    input  logic               hblank,
    input  logic [PIX_W-1:0]   pix_in,
    output logic [PIX_W-1:0]   pix_out
);
    localparam int OFF_W  = $clog2(DIM);
    localparam int WORDS  = (DIM * 2) / MEM_W;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int MB_SH  = $clog2(MEM_W / 8);
    localparam int BASE_W = ADDR_W - OFF_W - WIDX_W - MB_SH;
    localparam int PTR_W  = $clog2(STK);

    logic                        cur_en, enc_sel;
    logic [COORD_W-1:0]          pos_x, pos_y;
    logic [BASE_W-1:0]           base;
    logic [OFF_W-1:0]            off_x, off_y;
    logic [PIX_W-1:0]            fg0, bg0;
    logic [PTR_W-1:0]            fg_ptr;
    logic [WORDS-1:0][MEM_W-1:0] line_buf;
    logic                        line_ok;

    cur_regs #(
        .PIX_W(PIX_W), .COORD_W(COORD_W), .BASE_W(BASE_W), .OFF_W(OFF_W), .STK(STK)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .re(reg_re), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cur_en(cur_en), .enc_sel(enc_sel),
        .pos_x(pos_x), .pos_y(pos_y), .base(base), .off_x(off_x), .off_y(off_y),
        .fg0(fg0), .bg0(bg0), .fg_ptr(fg_ptr)
    );

    cur_fetch #(
        .COORD_W(COORD_W), .ADDR_W(ADDR_W), .DIM(DIM), .MEM_W(MEM_W)
    ) fetch_i (
        .clk(clk), .rst_n(rst_n), .hblank(hblank), .beam_y(beam_y), .pos_y(pos_y),
        .off_y(off_y), .base(base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .line_buf(line_buf), .line_ok(line_ok)
    );

    cur_mix #(
        .PIX_W(PIX_W), .COORD_W(COORD_W), .DIM(DIM), .MEM_W(MEM_W)
    ) mix_i (
        .clk(clk), .rst_n(rst_n), .beam_x(beam_x), .pix_in(pix_in), .pos_x(pos_x),
        .off_x(off_x), .cur_en(cur_en), .enc_sel(enc_sel), .fg(fg0), .bg(bg0),
        .line_buf(line_buf), .line_ok(line_ok), .pix_out(pix_out)
    );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int PIX_W   = 8,
    parameter int COORD_W = 11,
    parameter int ADDR_W  = 22,
    parameter int PTR_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic               reg_re,
    input logic [3:0]         reg_addr,
    input logic               cur_en,
    input logic [PIX_W-1:0]   pix_in,
    input logic [PIX_W-1:0]   pix_out,
    input logic               mem_req,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_ack,
    input logic [PTR_W-1:0]   fg_ptr,
    input logic [COORD_W-1:0] pos_y
);
    // R4
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_en |=> pix_out == $past(pix_in));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    // R2
    ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && !reg_we && reg_addr == 4'd10) |=> fg_ptr == '0);

    // R3
    ypos_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == 4'd4) |=> $stable(pos_y));
endmodule

bind cursor_overlay cursor_overlay_chk #(
    .PIX_W(PIX_W), .COORD_W(COORD_W), .ADDR_W(ADDR_W), .PTR_W($clog2(STK))
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .cur_en(cur_en), .pix_in(pix_in), .pix_out(pix_out), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .fg_ptr(fg_ptr), .pos_y(pos_y)
);

// File: tb/cursor_overlay_tb_top.sv
`timescale 1ns/1ps
module cursor_overlay_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_req;
    logic [21:0] mem_addr;
    logic        mem_ack;
    logic [15:0] mem_rdata;
    logic [10:0] beam_x = '0, beam_y = '0;
    logic        hblank = 1'b0;
    logic [7:0]  pix_in = '0;
    logic [7:0]  pix_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cursor_overlay dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .beam_x(beam_x), .beam_y(beam_y),
        .hblank(hblank), .pix_in(pix_in), .pix_out(pix_out)
    );

    // memory model: word pattern depends only on word slot within row
    function automatic logic [15:0] pat(input logic [21:0] a);
        case (a[3:1])
            3'd0:    pat = 16'hFF00;
            3'd1:    pat = 16'hF0F0;
            3'd3, 3'd5, 3'd7: pat = 16'hFFFF;
            default: pat = 16'h0000;
        endcase
    endfunction

    logic        clr_log = 1'b0;
    logic [21:0] alog [0:15];
    int          acnt;
    logic        ack_r = 1'b0;
    logic [15:0] rd_r = '0;
    assign mem_ack   = ack_r;
    assign mem_rdata = rd_r;

    always @(posedge clk) begin
        if (clr_log) acnt <= 0;
        if (!rst_n) begin
            ack_r <= 1'b0;
        end else if (mem_req && !ack_r) begin
            ack_r <= 1'b1;
            rd_r  <= pat(mem_addr);
            if (!clr_log && acnt < 16) begin
                alog[acnt] <= mem_addr;
                acnt <= acnt + 1;
            end
        end else begin
            ack_r <= 1'b0;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_re = 1'b0;
    endtask

    task automatic px(input logic [10:0] x, input logic [7:0] p, output logic [7:0] v);
        @(negedge clk);
        beam_x = x; pix_in = p;
        @(posedge clk); #1;
        v = pix_out;
    endtask

    task automatic line(input logic [10:0] l);
        @(negedge clk);
        beam_y = l - 11'd1; clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0; hblank = 1'b1;
        repeat (30) @(negedge clk);
        hblank = 1'b0; beam_y = l;
    endtask

    // {beam_x, pix_in, expected} with X=100, fg=3C, bg=C3, encoding 0
    localparam int NV = 12;
    localparam logic [26:0] VEC [NV] = '{
        {11'd99,  8'h21, 8'h21},
        {11'd100, 8'h0F, 8'hF0},
        {11'd103, 8'h55, 8'hAA},
        {11'd104, 8'h66, 8'h66},
        {11'd107, 8'h77, 8'h77},
        {11'd108, 8'h12, 8'h3C},
        {11'd111, 8'h13, 8'h3C},
        {11'd112, 8'h14, 8'hC3},
        {11'd115, 8'h15, 8'hC3},
        {11'd116, 8'h16, 8'h3C},
        {11'd163, 8'h17, 8'h3C},
        {11'd164, 8'h18, 8'h18}
    };

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        px(11'd0, 8'h33, v); chk("R1 pass after reset", v, 8'h33);
        rd(4'd10, v); chk("R1 fg reset", v, 8'hFF);
        rd(4'd11, v); chk("R1 bg reset", v, 8'h00);

        // R2 stack pointer behaviour
        wr(4'd10, 8'h3C); wr(4'd10, 8'h11);
        rd(4'd10, v); chk("R2 read at ptr 2", v, 8'hFF);
        rd(4'd10, v); chk("R2 read after reset ptr", v, 8'h3C);
        wr(4'd10, 8'h3C); wr(4'd10, 8'hB1); wr(4'd10, 8'hB2); wr(4'd10, 8'hB3);
        wr(4'd10, 8'hC0);
        rd(4'd10, v); chk("R2 wrap ptr 1", v, 8'hB1);
        rd(4'd10, v); chk("R2 wrap overwrote slot0", v, 8'hC0);
        wr(4'd10, 8'h3C);
        wr(4'd11, 8'hC3);

        // R3 staged position, origin still 0,0
        wr(4'd0, 8'h01);
        wr(4'd2, 8'h00); wr(4'd3, 8'd100); wr(4'd5, 8'h2C);
        line(11'd5);
        chk("R5 row5 addr", int'(alog[0]), 80);
        px(11'd2, 8'h0F, v); chk("R3 old origin in use", v, 8'hF0);
        wr(4'd4, 8'h01);
        wr(4'd6, 8'h00); wr(4'd7, 8'h03);

        // R9 line outside window
        line(11'd5);
        chk("R9 no fetch", acnt, 0);
        px(11'd2, 8'h0F, v); chk("R9 screen pixel", v, 8'h0F);

        // R5 fetch addresses
        line(11'd300);
        chk("R5 word count", acnt, 8);
        chk("R5 first addr", int'(alog[0]), 3072);
        chk("R5 last addr", int'(alog[7]), 3086);

        // R6 R8 R10 R11 table walk
        for (int i = 0; i < NV; i++) begin
            px(VEC[i][26:16], VEC[i][15:8], v);
            chk($sformatf("R6 R8 vec%0d", i), v, VEC[i][7:0]);
        end

        // R7 second encoding
        wr(4'd1, 8'h10);
        px(11'd100, 8'h44, v); chk("R7 11 fg", v, 8'h3C);
        px(11'd104, 8'h44, v); chk("R7 10 bg", v, 8'hC3);
        px(11'd108, 8'h44, v); chk("R7 01 screen", v, 8'h44);
        px(11'd112, 8'h45, v); chk("R7 00 screen", v, 8'h45);
        wr(4'd1, 8'h00);

        // R8 column offset
        wr(4'd8, 8'd4);
        px(11'd104, 8'h50, v); chk("R8 offx col8 fg", v, 8'h3C);
        px(11'd159, 8'h51, v); chk("R8 offx col63", v, 8'h3C);
        px(11'd160, 8'h52, v); chk("R8 offx col64 out", v, 8'h52);
        wr(4'd8, 8'd0);

        // R8 row offset
        wr(4'd9, 8'd60);
        line(11'd303);
        chk("R8 offy row63 addr", int'(alog[0]), 4080);
        px(11'd108, 8'h60, v); chk("R8 row63 fg", v, 8'h3C);
        line(11'd304);
        chk("R8 row64 no fetch", acnt, 0);
        px(11'd108, 8'h61, v); chk("R8 row64 screen", v, 8'h61);
        wr(4'd9, 8'd0);

        // R4 disable
        line(11'd300);
        wr(4'd0, 8'h00);
        px(11'd108, 8'h62, v); chk("R4 disabled screen", v, 8'h62);

        // R3 readback
        rd(4'd3, v); chk("R3 xlo read", v, 8'd100);
        rd(4'd4, v); chk("R3 yhi read", v, 8'h01);
        rd(4'd5, v); chk("R3 ylo read", v, 8'h2C);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule